// File: doc/BRIEF.md
# Boot Self-Load and Operating Mode Controller

This block decides how a clock generator comes up and how it behaves afterwards. A boot-select input picks one of two modes. Run mode is sticky: the first clock edge that sees the input high selects it, and only a reset leaves it. Program mode is active while the input has stayed low. In program mode the configuration registers are held at zero, so every clock output carries the plain reference. The two shared pins are passed through to a serial bus.

On entry to run mode the block reads a 128-bit nonvolatile store. It reads one byte per cycle, in ascending address order, and places each byte in the register file at the same index. A load counter keeps every clock output gated low for a fixed number of reference cycles, and the count length is a parameter. When the count ends, a done flag rises and normal operation begins.

After the load, the first shared pin acts as a power-down request. It acts only on the sections whose power-down bit is set in configuration byte 0. The second shared pin acts as an output enable for all four clock outputs. When every divider and every PLL is powered down, the oscillator enable drops.

Top module: `boot_mode_ctrl`

## Requirements
- R1: A clock edge that samples `boot_sel` high sets `run_mode` from the next cycle. `run_mode` then stays high whatever `boot_sel` does, until reset.
- R2: During the load, `mem_rd` is high and `mem_addr` counts 0 to 15, one step per cycle, starting in the first cycle of run mode. The byte presented at address k is written to `cfg_regs[8k+7:8k]`. After `load_done`, `cfg_regs` does not change.
- R3: `load_done` rises exactly LOAD_CYCLES cycles after `run_mode` rises. While `run_mode` is high and `load_done` is low, `clk_gate_en` is 0.
- R4: When the store is all zeros, after the load every output is enabled (`clk_gate_en`=4'hF, `pll_en`=3'h7, `osc_en`=1), even with the power-down pin high.
- R5: While `run_mode` is low, `cfg_regs` is zero, `load_done` is low, and `clk_gate_en`, `clk_oe`, `pll_en` and `osc_en` are all ones.
- R6: After the load, with `shared_pin_a` high, `clk_gate_en[i]` = NOT `cfg_regs[i]` for i in 0..3 and `pll_en[j]` = NOT `cfg_regs[4+j]` for j in 0..2. With the pin low, all are enabled.
- R7: `osc_en` is 0 only when the load is done, `shared_pin_a` is high and `cfg_regs[6:0]` is 7'h7F. Otherwise it is 1.
- R8: While `run_mode` is high, every bit of `clk_oe` equals `shared_pin_b` (0 means tristate).
- R9: While `run_mode` is low, `scl_out` follows `shared_pin_a` and `sda_out` follows `shared_pin_b`, and the pins have no effect on gating or enables. While `run_mode` is high, both `scl_out` and `sda_out` are 1.
- R10: After reset, `run_mode`=0, `load_done`=0 and `cfg_regs`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_sel | input | 1 | Mode select, high requests run mode |
| shared_pin_a | input | 1 | Power-down request in run mode, serial clock in program mode |
| shared_pin_b | input | 1 | Output enable in run mode, serial data in program mode |
| mem_rd | output | 1 | Store read strobe |
| mem_addr | output | 4 | Store byte address |
| mem_data | input | 8 | Store byte at `mem_addr`, same cycle |
| cfg_regs | output | 128 | Configuration register file |
| load_done | output | 1 | Self-load complete |
| run_mode | output | 1 | Latched run mode |
| clk_gate_en | output | 4 | Per-output gate, 0 forces the output low |
| clk_oe | output | 4 | Per-output drive enable, 0 tristates |
| pll_en | output | 3 | Per-PLL power enable |
| osc_en | output | 1 | Oscillator enable |
| scl_out | output | 1 | Serial clock to the bus |
| sda_out | output | 1 | Serial data to the bus |

## Verification
The assertions assume the store answers combinationally. They also assume that `boot_sel` and the shared pins are stable around each rising edge. The bench changes every input only at the falling edge and models the store as a bench array indexed by `mem_addr`. The assertions also assume that `LOAD_CYCLES` exceeds the byte count. The bench uses a short count of 40 so that the whole load falls inside one test.

// File: rtl/boot_pkg.sv
package boot_pkg;

    localparam int NUM_OUT   = 4;
    localparam int NUM_PLL   = 3;
    localparam int NUM_BYTES = 16;
    localparam int REG_BITS  = NUM_BYTES * 8;
    localparam int ADDR_W    = $clog2(NUM_BYTES);

    typedef enum logic [1:0] {
        ST_PROG = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } op_state_t;

    // power-down enable bits held in configuration byte 0
    typedef struct packed {
        logic [NUM_PLL-1:0] pll_pd;
        logic [NUM_OUT-1:0] div_pd;
    } pd_cfg_t;

    function automatic pd_cfg_t pd_from_byte(input logic [7:0] b);
        return pd_cfg_t'(b[NUM_PLL+NUM_OUT-1:0]);
    endfunction

    function automatic op_state_t state_of(input logic run, input logic done);
        if (!run)
            return ST_PROG;
        else if (!done)
            return ST_LOAD;
        return ST_RUN;
    endfunction

endpackage

// File: rtl/mode_latch.sv
module mode_latch (
    input  logic clk,
    input  logic rst,
    input  logic boot_sel,
    output logic run
);

    always_ff @(posedge clk) begin
        if (rst)
            run <= 1'b0;
        else if (boot_sel)
            run <= 1'b1;
    end

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        run |=> run); // R1

    AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (!run && !boot_sel) |=> !run); // R1

endmodule

// File: rtl/self_load.sv
module self_load #(
    parameter int LOAD_CYCLES = 89000,
    parameter int NUM_BYTES   = 16,
    localparam int AW = $clog2(NUM_BYTES),
    localparam int CW = $clog2(LOAD_CYCLES + 1),
    localparam int RB = NUM_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [7:0]    mem_data,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    output logic [RB-1:0] regs,
    output logic          done
);

    logic [CW-1:0] cnt;
    logic          in_fetch;

    assign in_fetch = cnt < CW'(NUM_BYTES);
    assign mem_rd   = run && !done && in_fetch;
    assign mem_addr = cnt[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            done <= 1'b0;
            regs <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
            if (in_fetch)
                regs[8*int'(cnt[AW-1:0]) +: 8] <= mem_data;
            if (cnt == CW'(LOAD_CYCLES - 1))
                done <= 1'b1;
        end
    end

    AST_DONE_AT_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> cnt == CW'(LOAD_CYCLES)); // R3

    AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (done && run) |=> $stable(regs)); // R2

    AST_NO_READ_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !done); // R2

endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import boot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  op_state_t          state,
    input  pd_cfg_t            pd_cfg,
    input  logic               pin_a,
    input  logic               pin_b,
    output logic [NUM_OUT-1:0] gate_en,
    output logic [NUM_OUT-1:0] oe,
    output logic [NUM_PLL-1:0] pll_en,
    output logic               osc_en,
    output logic               scl_out,
    output logic               sda_out
);

    logic [NUM_OUT-1:0] div_off;
    logic [NUM_PLL-1:0] pll_off;

    always_comb begin
        div_off = '0;
        pll_off = '0;
        gate_en = '1;
        oe      = '1;
        scl_out = 1'b1;
        sda_out = 1'b1;
        case (state)
            ST_PROG: begin
                scl_out = pin_a;
                sda_out = pin_b;
            end
            ST_LOAD: begin
                gate_en = '0;
                oe      = {NUM_OUT{pin_b}};
            end
            default: begin
                oe = {NUM_OUT{pin_b}};
                if (pin_a) begin
                    div_off = pd_cfg.div_pd;
                    pll_off = pd_cfg.pll_pd;
                end
                gate_en = ~div_off;
            end
        endcase
        pll_en = ~pll_off;
        osc_en = !((&div_off) && (&pll_off));
    end

    AST_OSC_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        !osc_en |-> (gate_en == '0 && pll_en == '0)); // R7

    AST_PD_LOW_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        !pin_a |-> (&pll_en && osc_en)); // R6

    AST_PROG_ON: assert property (@(posedge clk) disable iff (rst)
        state == ST_PROG |-> (&gate_en && &oe && osc_en)); // R5

endmodule

// File: rtl/boot_mode_ctrl.sv
module boot_mode_ctrl
    import boot_pkg::*;
#(
    parameter int LOAD_CYCLES = 89000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                boot_sel,
    input  logic                shared_pin_a,
    input  logic                shared_pin_b,
    output logic                mem_rd,
    output logic [ADDR_W-1:0]   mem_addr,
    input  logic [7:0]          mem_data,
    output logic [REG_BITS-1:0] cfg_regs,
    output logic                load_done,
    output logic                run_mode,
    output logic [NUM_OUT-1:0]  clk_gate_en,
    output logic [NUM_OUT-1:0]  clk_oe,
    output logic [NUM_PLL-1:0]  pll_en,
    output logic                osc_en,
    output logic                scl_out,
    output logic                sda_out
);

    op_state_t state;

    mode_latch u_latch (
        .clk      (clk),
        .rst      (rst),
        .boot_sel (boot_sel),
        .run      (run_mode)
    );

    self_load #(
        .LOAD_CYCLES (LOAD_CYCLES),
        .NUM_BYTES   (NUM_BYTES)
    ) u_load (
        .clk      (clk),
        .rst      (rst),
        .run      (run_mode),
        .mem_data (mem_data),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .regs     (cfg_regs),
        .done     (load_done)
    );

    assign state = state_of(run_mode, load_done);

    pin_mux u_mux (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .pd_cfg  (pd_from_byte(cfg_regs[7:0])),
        .pin_a   (shared_pin_a),
        .pin_b   (shared_pin_b),
        .gate_en (clk_gate_en),
        .oe      (clk_oe),
        .pll_en  (pll_en),
        .osc_en  (osc_en),
        .scl_out (scl_out),
        .sda_out (sda_out)
    );

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (rst)
        (run_mode && !load_done) |-> clk_gate_en == '0); // R3

    AST_PROG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run_mode |-> (cfg_regs == '0 && !load_done)); // R5

    AST_RUN_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
        run_mode |-> (scl_out && sda_out)); // R9

endmodule

// File: tb/boot_mode_ctrl_tb_top.sv
module boot_mode_ctrl_tb_top;

    localparam int L = 40;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         boot_sel = 1'b0;
    logic         pa = 1'b1;
    logic         pb = 1'b1;
    logic         mem_rd;
    logic [3:0]   mem_addr;
    logic [7:0]   mem_data;
    logic [127:0] cfg_regs;
    logic         load_done, run_mode, osc_en, scl_out, sda_out;
    logic [3:0]   clk_gate_en, clk_oe;
    logic [2:0]   pll_en;

    logic [7:0]   mem [16];
    assign mem_data = mem[mem_addr];

    boot_mode_ctrl #(.LOAD_CYCLES(L)) dut_i (
        .clk(clk), .rst(rst), .boot_sel(boot_sel),
        .shared_pin_a(pa), .shared_pin_b(pb),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .cfg_regs(cfg_regs), .load_done(load_done), .run_mode(run_mode),
        .clk_gate_en(clk_gate_en), .clk_oe(clk_oe), .pll_en(pll_en),
        .osc_en(osc_en), .scl_out(scl_out), .sda_out(sda_out)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    int           m_run = 0, m_done = 0, m_cnt = 0;
    logic [127:0] m_regs = '0;
    int           rise_cyc = 0;
    logic         prev_run = 0, prev_done = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_run = 0; m_done = 0; m_cnt = 0; m_regs = '0;
        end else begin
            if (m_run != 0 && m_done == 0) begin
                if (m_cnt < 16) m_regs[8*m_cnt +: 8] = mem[m_cnt];
                m_cnt++;
                if (m_cnt == L) m_done = 1;
            end
            if (boot_sel) m_run = 1;
        end
        #3;
        if (!rst) compare();
    end

    task automatic compare();
        logic [3:0] eg, eo;
        logic [2:0] ep;
        logic       eosc, escl, esda, erd;
        logic [7:0] b0;
        b0 = m_regs[7:0];
        eo = (m_run != 0) ? {4{pb}} : 4'hF;
        eg = 4'hF; ep = 3'h7; eosc = 1; escl = 1; esda = 1;
        erd = (m_run != 0 && m_done == 0 && m_cnt < 16);
        if (m_run == 0) begin
            escl = pa; esda = pb;
        end else if (m_done == 0) begin
            eg = 4'h0;
        end else if (pa) begin
            eg = ~b0[3:0]; ep = ~b0[6:4]; eosc = (b0[6:0] != 7'h7F);
        end
        chk(run_mode == (m_run != 0), "R1 run_mode", run_mode, m_run);
        chk(load_done == (m_done != 0), "R3 load_done", load_done, m_done);
        chk(cfg_regs == m_regs, m_run != 0 ? "R2 cfg_regs" : "R5 cfg_regs", cfg_regs, m_regs);
        chk(mem_rd == erd, "R2 mem_rd", mem_rd, erd);
        if (erd) chk(mem_addr == m_cnt[3:0], "R2 mem_addr", mem_addr, m_cnt);
        chk(clk_gate_en == eg, m_run == 0 ? "R5 gate" : (m_done == 0 ? "R3 gate" : "R6 gate"),
            clk_gate_en, eg);
        chk(pll_en == ep, "R6 pll_en", pll_en, ep);
        chk(osc_en == eosc, "R7 osc_en", osc_en, eosc);
        chk(clk_oe == eo, "R8 clk_oe", clk_oe, eo);
        chk(scl_out == escl && sda_out == esda, "R9 scl/sda", {scl_out, sda_out}, {escl, esda});
        if (run_mode && !prev_run) rise_cyc = cyc;
        if (load_done && !prev_done)
            chk(cyc - rise_cyc == L, "R3 load length", cyc - rise_cyc, L);
        prev_run = run_mode; prev_done = load_done;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; boot_sel = 0; pa = 1; pb = 1;
        step(2);
        rst = 0;
        prev_run = 0; prev_done = 0;
        #1;
        chk(run_mode == 0 && load_done == 0 && cfg_regs == '0, "R10 reset state",
            {run_mode, load_done, cfg_regs[7:0]}, 0);
    endtask

    task automatic load_mem(input logic [7:0] b0, input int seed);
        for (int i = 0; i < 16; i++) mem[i] = 8'(i * 17 + seed);
        mem[0] = b0;
    endtask

    initial begin : watchdog
        wait (cyc > 20000);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        // store of zeros, program mode with pin activity
        do_reset();
        for (int i = 0; i < 8; i++) begin
            pa = i[0]; pb = i[1];
            step(1);
        end
        pa = 1; pb = 1;
        boot_sel = 1; step(1); boot_sel = 0;  // R1: single-cycle request latches
        step(L + 6);
        chk(clk_gate_en == 4'hF && pll_en == 3'h7 && osc_en, "R4 zero store outputs",
            {clk_gate_en, pll_en, osc_en}, {4'hF, 3'h7, 1'b1});

        // patterned store, selective power-down
        load_mem(8'h35, 3);
        do_reset();
        step(3);
        boot_sel = 1;
        step(L + 4);
        begin
            logic [127:0] e;
            for (int i = 0; i < 16; i++) e[8*i +: 8] = mem[i];
            chk(cfg_regs == e, "R2 store copy", cfg_regs, e);
        end
        boot_sel = 0;
        for (int i = 0; i < 8; i++) begin
            pa = i[0]; pb = i[1];
            step(1);
        end

        // every section powered down: oscillator off
        load_mem(8'h7F, 9);
        do_reset();
        boot_sel = 1;
        step(L + 4);
        pa = 1; step(2);
        chk(osc_en == 0, "R7 all down", osc_en, 0);
        pa = 0; step(2);
        pa = 1; pb = 0; step(2);

        // dividers down, PLLs kept: oscillator on
        load_mem(8'h8F, 5);
        do_reset();
        boot_sel = 1;
        step(L + 4);
        pa = 1; step(2);
        chk(osc_en == 1 && clk_gate_en == 4'h0, "R7 partial down",
            {osc_en, clk_gate_en}, {1'b1, 4'h0});
        step(2);

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule